// File: doc/BRIEF.md
# Logical Device Resource Registers with I/O Range Check

This block stores the configuration of one logical device on a plug-and-play expansion card. The stored values are the bus enable, the conflict-test control, a set of I/O base addresses, interrupt level and mode, and DMA channel choices. A configuration sequencer outside the block reads and writes these registers through a byte-wide port. The port is addressed by the configuration index. Card-level state and the choice of which logical device is addressed stay outside the block.

A bus-side decoder compares each bus address against every programmed I/O window. Each window starts at its base and spans a fixed number of ports, set by a parameter. While the device is enabled, the decoder selects the device for reads and writes inside a window. While the device is disabled and the conflict test is on, reads inside a window are answered with a fixed pattern. Software reads the bus back and looks for a damaged pattern, which shows that another agent drives the same ports.

A configuration-reset pulse returns every register to its power-up value.

Top module: `ldev_res_regs`

## Requirements
- R1: After reset, every mapped index reads 0x00, except the two DMA indices 0x74 and 0x75, which read 0x04. No select and no test response is driven.
- R2: Index 0x30 keeps bit 0 as the device-enable flag. Bits 7:1 read back as zero whatever was written.
- R3: Index 0x31 keeps bit 1 (test enable) and bit 0 (pattern choice). Bits 7:2 read back as zero.
- R4: I/O window n (n = 0..7) keeps base bits 15:8 at index 0x60+2n and base bits 7:0 at index 0x61+2n. Both bytes read back as written.
- R5: Interrupt entry n (n = 0..1) keeps its level in bits 3:0 of index 0x70+2n, and the upper bits read zero. It keeps its mode in bits 1:0 of index 0x71+2n, with bit 1 = polarity high and bit 0 = level trigger. The mode's upper bits read zero. Both values appear on the interrupt outputs.
- R6: DMA entry n keeps bits 2:0 at index 0x74+n, and the upper bits read zero. The entry's valid output is low exactly when the channel is 4.
- R7: While the device is enabled, a bus read or write whose address lies in base..base+IO_LEN-1 of any window raises the device select in the same cycle. No wrap past address 0xFFFF is counted.
- R8: A window whose base is zero never matches.
- R9: While the device is disabled and test enable is set, a bus read inside a window raises the test drive. The test data is 0x55 when the pattern bit is 1 and 0xAA when it is 0. Otherwise the test data is 0x00.
- R10: The test response is never given for bus writes, and never while the device is enabled. In those cases the normal select applies instead.
- R11: A configuration-reset pulse restores every register to its R1 value on the next edge. It wins over a register write in the same cycle.
- R12: Writes to indices outside the mapped set change no register, and those indices read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_reset_i | input | 1 | Synchronous pulse that restores power-up values |
| reg_we_i | input | 1 | Register write strobe |
| reg_index_i | input | 8 | Configuration index |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Read data for the current index (combinational) |
| bus_addr_i | input | 16 | Bus I/O address |
| bus_rd_i | input | 1 | Bus read cycle |
| bus_wr_i | input | 1 | Bus write cycle |
| dev_sel_o | output | 1 | Device selected for this bus access |
| chk_drive_o | output | 1 | Test pattern is driven for this bus read |
| chk_data_o | output | 8 | Test pattern byte |
| dev_active_o | output | 1 | Device-enable flag |
| irq_level_o | output | NUM_IRQ*4 | Interrupt levels, entry n at bits 4n+3:4n |
| irq_mode_o | output | NUM_IRQ*2 | Interrupt modes, entry n: bit 2n+1 polarity, bit 2n trigger |
| dma_chan_o | output | NUM_DMA*3 | DMA channels, entry n at bits 3n+2:3n |
| dma_valid_o | output | NUM_DMA | DMA entry holds a channel other than 4 |

## Verification
A register write is captured on a rising edge. It shows on the readback and on the configuration outputs from that edge onward, which is one cycle after the write is presented. The readback, the device select and the test response follow the index and bus inputs in the same cycle, with no register in between. The bench changes inputs one nanosecond after each rising edge. It compares every output against its behavioural model at the following falling edge, and the model commits writes on the rising edge as the design does. Each comparison uses the value due in that very cycle.

// File: rtl/ldcfg_pkg.sv
package ldcfg_pkg;

  // Configuration index map (decoded by the register port)
  localparam logic [7:0] IDX_ACT    = 8'h30;
  localparam logic [7:0] IDX_RCHK   = 8'h31;
  localparam logic [7:0] IDX_IOBASE = 8'h60;
  localparam logic [7:0] IDX_IRQ    = 8'h70;
  localparam logic [7:0] IDX_DMA    = 8'h74;

  // Width of one I/O base address
  localparam int IO_ADDR_W = 16;

  // Channel code meaning "no DMA channel"
  localparam logic [2:0] DMA_NONE = 3'd4;

  // Range check answer bytes
  localparam logic [7:0] PAT_ONE  = 8'h55;
  localparam logic [7:0] PAT_ZERO = 8'hAA;

  typedef struct packed {
    logic en;   // test enable
    logic pat;  // pattern choice
  } rchk_t;

endpackage

// File: rtl/ldcfg_regfile.sv
module ldcfg_regfile
  import ldcfg_pkg::*;
#(
  parameter int NUM_IO  = 8,
  parameter int NUM_IRQ = 2,
  parameter int NUM_DMA = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cfg_reset,
  input  logic                        we,
  input  logic [7:0]                  index,
  input  logic [7:0]                  wdata,
  output logic [7:0]                  rdata,
  output logic                        act_o,
  output rchk_t                       rchk_o,
  output logic [NUM_IO*IO_ADDR_W-1:0] base_o,
  output logic [NUM_IRQ*4-1:0]        lvl_o,
  output logic [NUM_IRQ*2-1:0]        mode_o,
  output logic [NUM_DMA*3-1:0]        dma_o
);

  // State
  logic       act_q;
  rchk_t      rchk_q;
  logic [7:0] bhi_q  [NUM_IO];
  logic [7:0] blo_q  [NUM_IO];
  logic [3:0] lvl_q  [NUM_IRQ];
  logic [1:0] mode_q [NUM_IRQ];
  logic [2:0] dma_q  [NUM_DMA];

  // Next state and enables
  logic       act_en, act_d;
  logic       rchk_en;
  rchk_t      rchk_d;
  logic       bhi_en [NUM_IO];
  logic       blo_en [NUM_IO];
  logic [7:0] byte_d;
  logic       lvl_en  [NUM_IRQ];
  logic       mode_en [NUM_IRQ];
  logic [3:0] lvl_d;
  logic [1:0] mode_d;
  logic       dma_en [NUM_DMA];
  logic [2:0] dma_d;

  always_comb begin
    act_en  = cfg_reset | (we && index == IDX_ACT);
    act_d   = cfg_reset ? 1'b0 : wdata[0];
    rchk_en = cfg_reset | (we && index == IDX_RCHK);
    rchk_d  = cfg_reset ? '0 : rchk_t'{en: wdata[1], pat: wdata[0]};
    byte_d  = cfg_reset ? 8'h00 : wdata;
    lvl_d   = cfg_reset ? 4'h0 : wdata[3:0];
    mode_d  = cfg_reset ? 2'b00 : wdata[1:0];
    dma_d   = cfg_reset ? DMA_NONE : wdata[2:0];
    for (int i = 0; i < NUM_IO; i++) begin
      bhi_en[i] = cfg_reset | (we && index == 8'(IDX_IOBASE + 2*i));
      blo_en[i] = cfg_reset | (we && index == 8'(IDX_IOBASE + 2*i + 1));
    end
    for (int i = 0; i < NUM_IRQ; i++) begin
      lvl_en[i]  = cfg_reset | (we && index == 8'(IDX_IRQ + 2*i));
      mode_en[i] = cfg_reset | (we && index == 8'(IDX_IRQ + 2*i + 1));
    end
    for (int i = 0; i < NUM_DMA; i++) begin
      dma_en[i] = cfg_reset | (we && index == 8'(IDX_DMA + i));
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      act_q <= 1'b0;
    else if (act_en) act_q <= act_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rchk_q <= '0;
    else if (rchk_en) rchk_q <= rchk_d;
  end

  for (genvar g = 0; g < NUM_IO; g++) begin : g_io
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         bhi_q[g] <= 8'h00;
      else if (bhi_en[g]) bhi_q[g] <= byte_d;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         blo_q[g] <= 8'h00;
      else if (blo_en[g]) blo_q[g] <= byte_d;
    end
    assign base_o[g*IO_ADDR_W +: IO_ADDR_W] = {bhi_q[g], blo_q[g]};
  end

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_irq
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         lvl_q[g] <= 4'h0;
      else if (lvl_en[g]) lvl_q[g] <= lvl_d;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          mode_q[g] <= 2'b00;
      else if (mode_en[g]) mode_q[g] <= mode_d;
    end
    assign lvl_o[g*4 +: 4]  = lvl_q[g];
    assign mode_o[g*2 +: 2] = mode_q[g];
  end

  for (genvar g = 0; g < NUM_DMA; g++) begin : g_dma
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         dma_q[g] <= DMA_NONE;
      else if (dma_en[g]) dma_q[g] <= dma_d;
    end
    assign dma_o[g*3 +: 3] = dma_q[g];
  end

  assign act_o  = act_q;
  assign rchk_o = rchk_q;

  // Read mux
  always_comb begin
    rdata = 8'h00;
    if (index == IDX_ACT)  rdata = {7'b0, act_q};
    if (index == IDX_RCHK) rdata = {6'b0, rchk_q.en, rchk_q.pat};
    for (int i = 0; i < NUM_IO; i++) begin
      if (index == 8'(IDX_IOBASE + 2*i))     rdata = bhi_q[i];
      if (index == 8'(IDX_IOBASE + 2*i + 1)) rdata = blo_q[i];
    end
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (index == 8'(IDX_IRQ + 2*i))     rdata = {4'b0, lvl_q[i]};
      if (index == 8'(IDX_IRQ + 2*i + 1)) rdata = {6'b0, mode_q[i]};
    end
    for (int i = 0; i < NUM_DMA; i++) begin
      if (index == 8'(IDX_DMA + i)) rdata = {5'b0, dma_q[i]};
    end
  end

  // Enable flag follows a plain write
  assert_act_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (we && index == IDX_ACT && !cfg_reset) |=> (act_q == $past(wdata[0])));

  // First DMA entry follows a plain write
  assert_dma_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (we && index == IDX_DMA && !cfg_reset) |=> (dma_q[0] == $past(wdata[2:0])));

  // Configuration reset wins over everything
  assert_cfg_reset_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_reset |=> (!act_q && rchk_q == '0 && dma_q[0] == DMA_NONE && lvl_q[0] == 4'h0));

endmodule

// File: rtl/ldcfg_io_decode.sv
module ldcfg_io_decode
  import ldcfg_pkg::*;
#(
  parameter int NUM_IO = 8,
  parameter int IO_LEN = 8
) (
  input  logic                        act,
  input  rchk_t                       rchk,
  input  logic [NUM_IO*IO_ADDR_W-1:0] base_flat,
  input  logic [IO_ADDR_W-1:0]        bus_addr,
  input  logic                        bus_rd,
  input  logic                        bus_wr,
  output logic                        sel,
  output logic                        chk_drive,
  output logic [7:0]                  chk_data
);

  localparam int               EXT_W = IO_ADDR_W + 1;
  localparam logic [EXT_W-1:0] SPAN  = EXT_W'(IO_LEN - 1);

  logic [NUM_IO-1:0] hit;
  logic [EXT_W-1:0]  addr_ext;
  logic              any_hit;

  assign addr_ext = {1'b0, bus_addr};

  for (genvar g = 0; g < NUM_IO; g++) begin : g_win
    logic [IO_ADDR_W-1:0] base;
    logic [EXT_W-1:0]     lo, hi;
    assign base   = base_flat[g*IO_ADDR_W +: IO_ADDR_W];
    assign lo     = {1'b0, base};
    assign hi     = lo + SPAN;
    assign hit[g] = (base != '0) && (addr_ext >= lo) && (addr_ext <= hi);
  end

  always_comb begin
    any_hit   = |hit;
    sel       = act && any_hit && (bus_rd || bus_wr);
    chk_drive = !act && rchk.en && any_hit && bus_rd;
    chk_data  = chk_drive ? (rchk.pat ? PAT_ONE : PAT_ZERO) : 8'h00;
  end

endmodule

// File: rtl/ldev_res_regs.sv
module ldev_res_regs
  import ldcfg_pkg::*;
#(
  parameter int NUM_IO  = 8,
  parameter int NUM_IRQ = 2,
  parameter int NUM_DMA = 2,
  parameter int IO_LEN  = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_reset_i,
  input  logic                 reg_we_i,
  input  logic [7:0]           reg_index_i,
  input  logic [7:0]           reg_wdata_i,
  output logic [7:0]           reg_rdata_o,
  input  logic [15:0]          bus_addr_i,
  input  logic                 bus_rd_i,
  input  logic                 bus_wr_i,
  output logic                 dev_sel_o,
  output logic                 chk_drive_o,
  output logic [7:0]           chk_data_o,
  output logic                 dev_active_o,
  output logic [NUM_IRQ*4-1:0] irq_level_o,
  output logic [NUM_IRQ*2-1:0] irq_mode_o,
  output logic [NUM_DMA*3-1:0] dma_chan_o,
  output logic [NUM_DMA-1:0]   dma_valid_o
);

  logic                        act;
  rchk_t                       rchk;
  logic [NUM_IO*IO_ADDR_W-1:0] bases;

  ldcfg_regfile #(
    .NUM_IO (NUM_IO),
    .NUM_IRQ(NUM_IRQ),
    .NUM_DMA(NUM_DMA)
  ) i_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_reset(cfg_reset_i),
    .we       (reg_we_i),
    .index    (reg_index_i),
    .wdata    (reg_wdata_i),
    .rdata    (reg_rdata_o),
    .act_o    (act),
    .rchk_o   (rchk),
    .base_o   (bases),
    .lvl_o    (irq_level_o),
    .mode_o   (irq_mode_o),
    .dma_o    (dma_chan_o)
  );

  ldcfg_io_decode #(
    .NUM_IO(NUM_IO),
    .IO_LEN(IO_LEN)
  ) i_dec (
    .act      (act),
    .rchk     (rchk),
    .base_flat(bases),
    .bus_addr (bus_addr_i),
    .bus_rd   (bus_rd_i),
    .bus_wr   (bus_wr_i),
    .sel      (dev_sel_o),
    .chk_drive(chk_drive_o),
    .chk_data (chk_data_o)
  );

  for (genvar g = 0; g < NUM_DMA; g++) begin : g_dv
    assign dma_valid_o[g] = (dma_chan_o[g*3 +: 3] != DMA_NONE);
  end

  assign dev_active_o = act;

  // Select only while the stored enable flag is set
  assert_sel_needs_act_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dev_sel_o |-> act);

  // Test answer only on reads of a disabled device with test enabled
  assert_chk_only_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    chk_drive_o |-> (!act && rchk.en && bus_rd_i));

  // Test answer byte follows the stored pattern choice
  assert_chk_pattern_R9: assert property (@(posedge clk) disable iff (!rst_n)
    chk_drive_o |-> (chk_data_o == (rchk.pat ? 8'h55 : 8'hAA)));

endmodule

// File: tb/test_ldev_res_regs.sv
module test_ldev_res_regs;

  localparam int NIO = 8;
  localparam int LEN = 8;

  logic        clk;
  logic        rst_n;
  logic        cfg_reset_i;
  logic        reg_we_i;
  logic [7:0]  reg_index_i;
  logic [7:0]  reg_wdata_i;
  logic [7:0]  reg_rdata_o;
  logic [15:0] bus_addr_i;
  logic        bus_rd_i;
  logic        bus_wr_i;
  logic        dev_sel_o;
  logic        chk_drive_o;
  logic [7:0]  chk_data_o;
  logic        dev_active_o;
  logic [7:0]  irq_level_o;
  logic [3:0]  irq_mode_o;
  logic [5:0]  dma_chan_o;
  logic [1:0]  dma_valid_o;

  ldev_res_regs i_ldev_res_regs (
    .clk(clk), .rst_n(rst_n), .cfg_reset_i(cfg_reset_i),
    .reg_we_i(reg_we_i), .reg_index_i(reg_index_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .bus_addr_i(bus_addr_i), .bus_rd_i(bus_rd_i),
    .bus_wr_i(bus_wr_i), .dev_sel_o(dev_sel_o), .chk_drive_o(chk_drive_o),
    .chk_data_o(chk_data_o), .dev_active_o(dev_active_o),
    .irq_level_o(irq_level_o), .irq_mode_o(irq_mode_o),
    .dma_chan_o(dma_chan_o), .dma_valid_o(dma_valid_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int    checks = 0;
  int    failures = 0;
  bit    done = 0;
  string cur_req = "R1";

  // Behavioural reference state
  int m_act, m_en, m_pat;
  int m_base[NIO];
  int m_lvl[2], m_mode[2], m_dma[2];

  task automatic m_reset();
    m_act = 0; m_en = 0; m_pat = 0;
    for (int i = 0; i < NIO; i++) m_base[i] = 0;
    for (int i = 0; i < 2; i++) begin m_lvl[i] = 0; m_mode[i] = 0; m_dma[i] = 4; end
  endtask

  function automatic int mread(int idx);
    if (idx == 'h30) return m_act;
    if (idx == 'h31) return m_en * 2 + m_pat;
    if (idx >= 'h60 && idx < 'h60 + 2*NIO)
      return ((idx - 'h60) % 2) ? (m_base[(idx - 'h60) / 2] & 'hFF)
                                : (m_base[(idx - 'h60) / 2] >> 8);
    if (idx >= 'h70 && idx < 'h74)
      return ((idx - 'h70) % 2) ? m_mode[(idx - 'h70) / 2] : m_lvl[(idx - 'h70) / 2];
    if (idx == 'h74 || idx == 'h75) return m_dma[idx - 'h74];
    return 0;
  endfunction

  task automatic mwrite(int idx, int d);
    if (idx == 'h30) m_act = d & 1;
    else if (idx == 'h31) begin m_en = (d >> 1) & 1; m_pat = d & 1; end
    else if (idx >= 'h60 && idx < 'h60 + 2*NIO) begin
      if ((idx - 'h60) % 2) m_base[(idx - 'h60) / 2] = (m_base[(idx - 'h60) / 2] & 'hFF00) | d;
      else                  m_base[(idx - 'h60) / 2] = (m_base[(idx - 'h60) / 2] & 'hFF) | (d << 8);
    end
    else if (idx >= 'h70 && idx < 'h74) begin
      if ((idx - 'h70) % 2) m_mode[(idx - 'h70) / 2] = d & 3;
      else                  m_lvl[(idx - 'h70) / 2] = d & 15;
    end
    else if (idx == 'h74 || idx == 'h75) m_dma[idx - 'h74] = d & 7;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) m_reset();
    else if (cfg_reset_i) m_reset();
    else if (reg_we_i) mwrite(int'(reg_index_i), int'(reg_wdata_i));
  end

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", cur_req, what, act, exp);
    end
  endtask

  // Compare every output against the model at each falling edge
  always @(negedge clk) begin
    if (!done) begin
      int a, hit, e_sel, e_drv;
      a = int'(bus_addr_i);
      hit = 0;
      for (int i = 0; i < NIO; i++)
        if (m_base[i] != 0 && a >= m_base[i] && a <= m_base[i] + LEN - 1) hit = 1;
      e_sel = (m_act && hit && (bus_rd_i || bus_wr_i)) ? 1 : 0;
      e_drv = (!m_act && m_en && hit && bus_rd_i) ? 1 : 0;
      chk("rdata", int'(reg_rdata_o), mread(int'(reg_index_i)));
      chk("dev_sel", int'(dev_sel_o), e_sel);
      chk("chk_drive", int'(chk_drive_o), e_drv);
      chk("chk_data", int'(chk_data_o), e_drv ? (m_pat ? 'h55 : 'hAA) : 0);
      chk("active", int'(dev_active_o), m_act);
      for (int n = 0; n < 2; n++) begin
        chk("irq_level", int'(irq_level_o[n*4 +: 4]), m_lvl[n]);
        chk("irq_mode", int'(irq_mode_o[n*2 +: 2]), m_mode[n]);
        chk("dma_chan", int'(dma_chan_o[n*3 +: 3]), m_dma[n]);
        chk("dma_valid", int'(dma_valid_o[n]), (m_dma[n] != 4) ? 1 : 0);
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(int idx, int d);
    reg_we_i = 1'b1; reg_index_i = 8'(idx); reg_wdata_i = 8'(d);
    step();
    reg_we_i = 1'b0;
  endtask

  task automatic rd(int idx);
    reg_index_i = 8'(idx);
    step();
  endtask

  task automatic bus(int addr, bit r, bit w);
    bus_addr_i = 16'(addr); bus_rd_i = r; bus_wr_i = w;
    step();
    bus_rd_i = 1'b0; bus_wr_i = 1'b0;
  endtask

  task automatic sweep();
    rd('h30); rd('h31);
    for (int i = 'h60; i <= 'h75; i++) rd(i);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    m_reset();
    rst_n = 1'b1; cfg_reset_i = 1'b0; reg_we_i = 1'b0; reg_index_i = 8'h00;
    reg_wdata_i = 8'h00; bus_addr_i = 16'h0000; bus_rd_i = 1'b0; bus_wr_i = 1'b0;
    #1 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    cur_req = "R1"; sweep(); bus('h0000, 1, 0);
    cur_req = "R2"; wr('h30, 'hFF); rd('h30); wr('h30, 'h00); rd('h30);
    cur_req = "R3"; wr('h31, 'hFF); rd('h31); wr('h31, 'hFD); rd('h31); wr('h31, 0);
    cur_req = "R4";
    wr('h60, 'h03); wr('h61, 'h00); wr('h6E, 'h12); wr('h6F, 'h34);
    wr('h66, 'hFF); wr('h67, 'hFC); sweep();
    cur_req = "R5"; wr('h70, 'hFA); wr('h71, 'hFF); wr('h73, 'h02); wr('h72, 'h07); sweep();
    cur_req = "R6"; wr('h74, 'hF9); wr('h75, 'h04); rd('h74); rd('h75); wr('h75, 'h00); rd('h75);
    cur_req = "R7"; wr('h30, 1);
    bus('h02FF, 1, 0); bus('h0300, 1, 0); bus('h0307, 0, 1); bus('h0308, 1, 0);
    bus('h1234, 1, 0); bus('h123B, 0, 1); bus('h123C, 1, 0); bus('hFFFF, 1, 0);
    bus('h0000, 1, 0); bus('h0003, 0, 1); bus('h1235, 0, 0);
    cur_req = "R8"; wr('h60, 0); bus('h0300, 1, 0); bus('h0000, 1, 0); bus('h0005, 0, 1);
    cur_req = "R9"; wr('h30, 0); wr('h31, 3);
    bus('h1234, 1, 0); bus('h1233, 1, 0); bus('hFFFE, 1, 0);
    wr('h31, 2); bus('h123B, 1, 0); wr('h31, 1); bus('h1234, 1, 0);
    cur_req = "R10"; wr('h31, 3); bus('h1234, 0, 1); bus('h1236, 1, 1);
    wr('h30, 1); bus('h1234, 1, 0); bus('hFFFD, 1, 0);
    cur_req = "R11";
    cfg_reset_i = 1'b1; reg_we_i = 1'b1; reg_index_i = 8'h30; reg_wdata_i = 8'h01;
    step();
    cfg_reset_i = 1'b0; reg_we_i = 1'b0;
    sweep(); bus('h1234, 1, 0);
    cur_req = "R12"; wr('h6E, 'h40); wr('h32, 'hFF); wr('h50, 'hFF); wr('h76, 'hFF);
    wr('h2F, 'hFF); wr('h00, 'hFF);
    rd('h32); rd('h50); rd('h76); rd('h2F); rd('h00); sweep();
    bus('h4000, 1, 0);

    step();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule